// File: doc/BRIEF.md
# Busy-Aware Read Data Path

This block sits between a byte-wide nonvolatile array and the tristate data pins of a paged memory. While no programming cycle is running, an access with chip-enable and output-enable low and write-enable high returns the stored byte at the requested address. While the write controller reports that the array is busy programming, the same access returns a status byte instead of array data. Software polls this status byte to find out when the write has completed.

The status byte carries two separate completion indicators. Bit 7 shows the inverse of bit 7 of the last byte that was loaded. Bit 6 flips once for every new read access. The remaining bits repeat the matching bits of the last loaded byte. When programming ends, reads return true array contents on every bit, and bit 6 stops changing. The toggle state is kept while the array is idle, so a later busy interval continues from wherever the previous one stopped.

All strobes are sampled on the system clock. The data byte and its output-enable are registered, so they change one clock after the inputs that cause them.

Top module: `status_read_path`

## Requirements
- R1: While reset is asserted, `dout_oe` is 0 and `dout` is 0x00.
- R2: `dout_oe` is 1 exactly in the clock after a cycle in which `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other case it is 0, including when `we_n` is 0 with both other strobes low.
- R3: When `busy` is 0 during a read cycle, `dout` in the next clock equals `arr_rdata` from that cycle.
- R4: When `busy` is 1 during a read cycle, `dout[7]` in the next clock equals the inverse of `last_wr[7]`.
- R5: When `busy` is 1, `dout[6]` inverts at the start of each new read access relative to the previous busy read. A new access is a cycle with read conditions true that follows a cycle without them. `dout[6]` holds its value for as long as a single access continues.
- R6: When `busy` is 1 during a read cycle, `dout[5:0]` in the next clock equals `last_wr[5:0]`.
- R7: Once `busy` is 0, reads return `arr_rdata` on all eight bits. Reads made while idle do not advance the toggle, and the next busy read shows the inverse of the last busy value of bit 6.
- R8: Polling may begin at any point. If `busy` rises while an access is already in progress, `dout` switches to the status byte in the next clock without a toggle advance. If an access starts in the same cycle that `busy` falls, it returns array data.
- R9: A cycle with `we_n`=0 does not count as a read access and does not advance the toggle.
- R10: `arr_addr` equals `addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW (17) | Byte address of the access |
| busy | input | 1 | Programming in progress, from the write controller |
| last_wr | input | DW (8) | Last byte loaded by the write controller |
| arr_rdata | input | DW (8) | Array data at `arr_addr` |
| arr_addr | output | AW (17) | Read address presented to the array |
| dout | output | DW (8) | Data byte to the pin driver |
| dout_oe | output | 1 | Enable for the tristate pin driver |

## Verification
Two events can land in the same clock: the start of a read access, which advances the toggle, and a change of `busy`, which chooses between status and array data. The bench starts an access in the exact cycle that `busy` falls and expects the true array byte. It also starts an access in the cycle that `busy` rises and expects the status byte with bit 6 already advanced. Separately, it raises `busy` in the middle of a running access and judges that the status byte appears without a toggle step.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic {
    SRC_ARRAY  = 1'b0,
    SRC_STATUS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/srp_strobe.sv
module srp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_act,
  output logic rd_start
);
  logic rd_prev_q;
  logic rd_prev_d;

  always_comb begin
    rd_act    = ~ce_n & ~oe_n & we_n;
    rd_start  = rd_act & ~rd_prev_q;
    rd_prev_d = rd_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev_q <= 1'b0;
    else        rd_prev_q <= rd_prev_d;
  end
endmodule

// File: rtl/srp_toggle.sv
module srp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic tgl_nxt
);
  logic tgl_q;

  always_comb begin
    tgl_nxt = adv ? ~tgl_q : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tgl_q <= 1'b0;
    else if (adv) tgl_q <= tgl_nxt;
  end
endmodule

// File: rtl/srp_outmux.sv
module srp_outmux #(
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input  srp_pkg::rd_src_e src,
  input  logic [DW-1:0]    arr_rdata,
  input  logic [DW-1:0]    last_wr,
  input  logic             tgl,
  output logic [DW-1:0]    data
);
  logic [DW-1:0] stat;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign stat[i] = ~last_wr[i];
    end else if (i == TGL_BIT) begin : g_tgl
      assign stat[i] = tgl;
    end else begin : g_pass
      assign stat[i] = last_wr[i];
    end
  end

  always_comb begin
    data = (src == srp_pkg::SRC_STATUS) ? stat : arr_rdata;
  end
endmodule

// File: rtl/status_read_path.sv
module status_read_path #(
  parameter int DW       = 8,
  parameter int AW       = 17,
  parameter int POLL_BIT = DW - 1,
  parameter int TGL_BIT  = DW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  input  logic [DW-1:0] last_wr,
  input  logic [DW-1:0] arr_rdata,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  import srp_pkg::*;

  logic          rd_act;
  logic          rd_start;
  logic          tgl_adv;
  logic          tgl_nxt;
  rd_src_e       src;
  logic [DW-1:0] mux_data;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] dout_d;
  logic          dout_oe_q;
  logic          dout_oe_d;
  logic          dout_en;

  assign arr_addr = addr;

  srp_strobe u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .rd_act   (rd_act),
    .rd_start (rd_start)
  );

  assign tgl_adv = rd_start & busy;

  srp_toggle u_toggle (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (tgl_adv),
    .tgl_nxt (tgl_nxt)
  );

  assign src = busy ? SRC_STATUS : SRC_ARRAY;

  srp_outmux #(
    .DW       (DW),
    .POLL_BIT (POLL_BIT),
    .TGL_BIT  (TGL_BIT)
  ) u_outmux (
    .src       (src),
    .arr_rdata (arr_rdata),
    .last_wr   (last_wr),
    .tgl       (tgl_nxt),
    .data      (mux_data)
  );

  always_comb begin
    dout_en   = rd_act;
    dout_d    = mux_data;
    dout_oe_d = rd_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      dout_oe_q <= 1'b0;
    end else begin
      dout_oe_q <= dout_oe_d;
      if (dout_en) dout_q <= dout_d;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = dout_oe_q;
endmodule

// File: rtl/status_read_path_chk.sv
module status_read_path_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          busy,
  input logic [DW-1:0] last_wr,
  input logic [DW-1:0] arr_rdata,
  input logic [DW-1:0] dout,
  input logic          dout_oe
);
  logic rd;
  logic pv1_q;
  logic pv2_q;

  assign rd = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv1_q <= 1'b0;
      pv2_q <= 1'b0;
    end else begin
      pv1_q <= 1'b1;
      pv2_q <= pv1_q;
    end
  end

  // R1: reset clears the pin enable and the data byte
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!dout_oe && dout == '0);
    end
  end

  a_r2_oe_tracks_read: assert property (@(posedge clk) disable iff (!rst_n)
    pv1_q |-> dout_oe == $past(rd));

  a_r3_idle_true_data: assert property (@(posedge clk) disable iff (!rst_n)
    pv1_q && $past(rd && !busy) |-> dout == $past(arr_rdata));

  a_r4_poll_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    pv1_q && $past(rd && busy) |-> dout[DW-1] == ~$past(last_wr[DW-1]));

  a_r5_toggle_held: assert property (@(posedge clk) disable iff (!rst_n)
    pv2_q && $past(rd && busy) && $past(rd && busy, 2) |-> dout[DW-2] == $past(dout[DW-2]));

  a_r6_low_bits_echo: assert property (@(posedge clk) disable iff (!rst_n)
    pv1_q && $past(rd && busy) |-> dout[DW-3:0] == $past(last_wr[DW-3:0]));
endmodule

bind status_read_path status_read_path_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .busy      (busy),
  .last_wr   (last_wr),
  .arr_rdata (arr_rdata),
  .dout      (dout),
  .dout_oe   (dout_oe)
);

// File: tb/status_read_path_tb.sv
module status_read_path_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  logic        clk;
  logic        rst_n;
  logic        ce_n;
  logic        oe_n;
  logic        we_n;
  logic [16:0] addr;
  logic        busy;
  logic [7:0]  last_wr;
  logic [7:0]  arr_rdata;
  logic [16:0] arr_addr;
  logic [7:0]  dout;
  logic        dout_oe;

  int n_chk;
  int n_bad;
  int cycles;

  // {ce_n, oe_n, we_n, busy, last_wr, arr_rdata, exp_oe, exp_dout, mask}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA5, 1'b1, 8'hA5, 8'hFF}, // R3 idle read
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h5A, 1'b0, 8'h00, 8'h00}, // R2 chip deselected
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h5A, 1'b0, 8'h00, 8'h00}, // R2 output disabled
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b0, 8'h00, 8'h00}, // R2 R9 write enable low
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hFF, 1'b1, 8'hBC, 8'hBF}, // R4 R6 status byte
    {1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, 8'h00, 1'b1, 8'h03, 8'hBF}, // R4 R6 status, new last byte
    {1'b0, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h5A, 1'b1, 8'h5A, 8'hFF}  // R7 back to array data
  };

  status_read_path u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .busy      (busy),
    .last_wr   (last_wr),
    .arr_rdata (arr_rdata),
    .arr_addr  (arr_addr),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles, expected under 5000", cycles);
        summary();
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp,
                     input logic [7:0] mask);
    n_chk++;
    if ((act & mask) !== (exp & mask)) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h (mask %02h)", req, act, exp, mask);
    end
  endtask

  task automatic apply(input logic c, input logic o, input logic w, input logic b,
                       input logic [7:0] lw, input logic [7:0] ar);
    ce_n = c; oe_n = o; we_n = w; busy = b; last_wr = lw; arr_rdata = ar;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic b);
    apply(1'b1, 1'b1, 1'b1, b, 8'h3C, 8'h00);
  endtask

  logic cur;
  logic [7:0] seen;

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; busy = 1'b0; last_wr = '0; arr_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", {7'd0, dout_oe}, 8'h00, 8'hFF);
    chk("R1", dout, 8'h00, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 address passthrough
    addr = 17'h1_2AB5; #1;
    chk("R10", arr_addr[7:0], 8'hB5, 8'hFF);
    chk("R10", {7'd0, arr_addr[16]}, 8'h01, 8'hFF);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32:25], VEC[i][24:17]);
      chk($sformatf("vec%0d R2", i), {7'd0, dout_oe}, {7'd0, VEC[i][16]}, 8'hFF);
      chk($sformatf("vec%0d R3/R4/R6/R7", i), dout, VEC[i][15:8], VEC[i][7:0]);
    end

    // R5: toggle alternates per access, holds within an access
    idle(1'b1);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h00);
    cur = dout[6];
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h00);
    chk("R5 hold", {7'd0, dout[6]}, {7'd0, cur}, 8'hFF);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h00);
    chk("R5 hold", {7'd0, dout[6]}, {7'd0, cur}, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      idle(1'b1);
      apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h00);
      chk("R5 flip", {7'd0, dout[6]}, {7'd0, ~cur}, 8'hFF);
      cur = dout[6];
    end

    // R9: write-enable low is not a read access
    idle(1'b1);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h00);
    chk("R9 oe", {7'd0, dout_oe}, 8'h00, 8'hFF);
    idle(1'b1);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h00);
    chk("R9 single flip", {7'd0, dout[6]}, {7'd0, ~cur}, 8'hFF);
    cur = dout[6];

    // R7: idle reads return true data, toggle kept
    for (int k = 0; k < 2; k++) begin
      idle(1'b0);
      apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h40);
      chk("R7 true data", dout, 8'h40, 8'hFF);
    end
    idle(1'b1);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h40);
    chk("R7 toggle kept", {7'd0, dout[6]}, {7'd0, ~cur}, 8'hFF);
    cur = dout[6];

    // R8: access starts as busy falls
    idle(1'b1);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h99);
    chk("R8 start at busy fall", dout, 8'h99, 8'hFF);
    // R8: access starts as busy rises
    idle(1'b0);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h0F, 8'h99);
    seen = {~cur, 7'd0};
    chk("R8 start at busy rise", dout, {1'b1, seen[7], 6'h0F}, 8'hFF);
    cur = dout[6];
    // R8: busy rises inside a running access
    idle(1'b0);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h11);
    chk("R8 before rise", dout, 8'h11, 8'hFF);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h80, 8'h11);
    chk("R8 mid-access status", dout, {1'b0, cur, 6'h00}, 8'hFF);

    idle(1'b0);
    summary();
  end
endmodule